// File: doc/BRIEF.md
# Serial SAR Converter Host Sequencer

This block drives a 12-bit serial successive-approximation converter from the host side. On a start request it raises the convert line, waits a fixed number of system clocks that covers the worst-case conversion time, and then runs one serial frame of 12 clock pulses. During that frame it sends a 6-bit setup word MSB first and collects the 12 result bits. The setup word selects the input pairing and the output format for the *following* conversion.

Because of that one-conversion lag, the block keeps a two-deep history of setup words. Each returned sample carries the setup that produced it. The first sample after reset came from a conversion whose setup was never sent, so it is marked stale. A sleep option keeps the convert line high for the whole conversion time; otherwise the convert line is a short pulse. All timing is set in system-clock cycles through parameters: convert pulse width, conversion wait, serial half period, acquisition time and minimum cycle spacing.

Top module: `sarh_host_ctrl`

## Requirements
- R1: While reset is asserted and after reset is released, conv_o, sck_o, sdi_o and result_valid_o are low until the first accepted start.
- R2: A start is accepted only when the block is idle and both spacing counters have expired; start_i at any other time has no effect. In normal mode conv_o rises on the accepted start and stays high for exactly CONV_HI_CYC cycles.
- R3: In sleep mode, which sleep_i selects at the accepted start, conv_o stays high for exactly CONV_CYC cycles and falls when the conversion wait ends.
- R4: The first sck_o rise follows the conv_o rise by exactly CONV_CYC+SCK_HALF cycles. Every sck_o high and low phase lasts exactly SCK_HALF cycles. A frame has exactly 12 pulses, and sck_o rests low.
- R5: The setup word goes out on sdi_o MSB first as {single, odd, 0, 0, unipolar, 0}. The first bit is valid before the first sck_o rise, and each later bit changes after a falling edge. sdi_o is low from the 6th falling edge onward.
- R6: sdo_i is sampled at each sck_o rise. The first sample is result bit 11, which is valid before any clocking, and the last is bit 0. result_o updates, and result_valid_o pulses for one cycle, at the 12th falling edge.
- R7: result_tag_o = {single, odd, unipolar} is the setup sent in the previous frame, which is the setup of the conversion being returned. These inputs are latched at the accepted start, so later changes to them have no effect.
- R8: result_stale_o is 1 on the first result after reset and 0 on every later one.
- R9: Two conv_o rises are at least CYCLE_CYC cycles apart, and a conv_o rise comes at least ACQ_CYC cycles after the 6th sck_o rise. With start_i held high, rises come exactly CYCLE_CYC cycles apart whenever the frame is shorter than that spacing.
- R10: result_o carries the 12 received bits unaltered, so straight binary and two's complement codes pass through without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request |
| single_i | input | 1 | 1: single-ended to ground, 0: differential pair |
| odd_i | input | 1 | Selects the odd channel, or reverses the pair |
| unipolar_i | input | 1 | 1: straight binary range, 0: two's complement range |
| sleep_i | input | 1 | Hold the convert line high through the conversion |
| sdo_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Convert-start line |
| sck_o | output | 1 | Serial clock |
| sdi_o | output | 1 | Serial setup data to the converter |
| result_o | output | DATA_W | Last received sample |
| result_valid_o | output | 1 | One-cycle strobe for a new sample |
| result_tag_o | output | 3 | {single, odd, unipolar} of the returned sample |
| result_stale_o | output | 1 | Sample belongs to the setup before the first one sent |

## Verification
The bench sweeps all sixteen combinations of pairing, range and sleep, running frames back to back, and a behavioural converter model rebuilds each sample from the setup word it actually received. If the design tagged a sample with the current setup instead of the previous one, every tag would be off by one frame. If the setup bits were sent in the wrong order, the model would return codes that do not match the prediction. If the MSB capture were dropped or shifted, every result would come back shifted one bit. A start pulsed in the middle of a frame, and input changes after a start, are used to show that a design that restarts or fails to latch its settings is caught through the conv_o rise count and the tags. Edge spacing is measured exactly, so an off-by-one in the conversion wait, the half period or the cycle spacing shows up as a wrong count.

// File: rtl/sarh_pkg.sv
package sarh_pkg;
  localparam int SARH_CFG_W = 6;

  typedef struct packed {
    logic single;
    logic odd;
    logic unipolar;
  } sarh_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_LEAD, ST_SHIFT} sarh_state_e;

  // serial setup word, MSB first on the wire
  function automatic logic [SARH_CFG_W-1:0] sarh_word(sarh_cfg_t c);
    return {c.single, c.odd, 2'b00, c.unipolar, 1'b0};
  endfunction
endpackage

// File: rtl/sarh_sck_div.sv
module sarh_sck_div #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= CW'(HALF - 1);
    else if (!run_i || tick_o)   cnt_q <= CW'(HALF - 1);
    else                         cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sarh_frame_shift.sv
module sarh_frame_shift
  import sarh_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [SARH_CFG_W-1:0] word_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  sdo_i,
  output logic                  sdi_o,
  output logic [DATA_W-1:0]     data_o
);
  logic [SARH_CFG_W-1:0] out_sr_q;
  logic                  sdi_q;
  logic [DATA_W-1:0]     in_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_sr_q <= '0;
      sdi_q    <= 1'b0;
    end else if (load_i) begin
      sdi_q    <= word_i[SARH_CFG_W-1];
      out_sr_q <= {word_i[SARH_CFG_W-2:0], 1'b0};
    end else if (fall_i) begin
      sdi_q    <= out_sr_q[SARH_CFG_W-1];
      out_sr_q <= {out_sr_q[SARH_CFG_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     in_sr_q <= '0;
    else if (rise_i) in_sr_q <= {in_sr_q[DATA_W-2:0], sdo_i};
  end

  assign sdi_o  = sdi_q;
  assign data_o = in_sr_q;
endmodule

// File: rtl/sarh_cfg_hist.sv
module sarh_cfg_hist
  import sarh_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  sarh_cfg_t cfg_i,
  output sarh_cfg_t prev_o,
  output logic      prev_vld_o
);
  sarh_cfg_t ent_q [2];
  logic [1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q[0] <= '0;
      ent_q[1] <= '0;
      vld_q    <= 2'b00;
    end else if (push_i) begin
      ent_q[0] <= cfg_i;
      ent_q[1] <= ent_q[0];
      vld_q    <= {vld_q[0], 1'b1};
    end
  end

  assign prev_o     = ent_q[1];
  assign prev_vld_o = vld_q[1];
endmodule

// File: rtl/sarh_host_ctrl.sv
module sarh_host_ctrl
  import sarh_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SCK_HALF    = 2,
  parameter int CONV_HI_CYC = 2,
  parameter int CONV_CYC    = 10,
  parameter int ACQ_CYC     = 12,
  parameter int CYCLE_CYC   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              single_i,
  input  logic              odd_i,
  input  logic              unipolar_i,
  input  logic              sleep_i,
  input  logic              sdo_i,
  output logic              conv_o,
  output logic              sck_o,
  output logic              sdi_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o,
  output logic [2:0]        result_tag_o,
  output logic              result_stale_o
);
  localparam int CNV_W = $clog2(CONV_CYC + 1);
  localparam int CYC_W = $clog2(CYCLE_CYC + 1);
  localparam int ACQ_W = $clog2(ACQ_CYC + 1);
  localparam int RC_W  = $clog2(DATA_W + 1);

  sarh_state_e       state_q;
  logic [CNV_W-1:0]  cnv_cnt_q;
  logic [CYC_W-1:0]  cyc_cnt_q;
  logic [ACQ_W-1:0]  acq_cnt_q;
  logic [RC_W-1:0]   rise_cnt_q;
  logic              conv_q, sck_q, sleep_q;
  logic              valid_q, stale_q;
  logic [DATA_W-1:0] result_q;
  logic [2:0]        tag_q;

  logic              accept, tick, run, rise, fall, prev_vld;
  sarh_cfg_t         cfg_in, prev_cfg;
  logic [DATA_W-1:0] shift_data;

  assign cfg_in = '{single: single_i, odd: odd_i, unipolar: unipolar_i};
  assign accept = (state_q == ST_IDLE) && start_i && (cyc_cnt_q == '0) && (acq_cnt_q == '0);
  assign run    = (state_q == ST_LEAD) || (state_q == ST_SHIFT);
  assign rise   = tick && ((state_q == ST_LEAD) || ((state_q == ST_SHIFT) && !sck_q));
  assign fall   = tick && (state_q == ST_SHIFT) && sck_q;

  sarh_sck_div #(.HALF(SCK_HALF)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  sarh_frame_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .word_i (sarh_word(cfg_in)),
    .rise_i (rise),
    .fall_i (fall),
    .sdo_i  (sdo_i),
    .sdi_o  (sdi_o),
    .data_o (shift_data)
  );

  sarh_cfg_hist u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (accept),
    .cfg_i      (cfg_in),
    .prev_o     (prev_cfg),
    .prev_vld_o (prev_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnv_cnt_q  <= '0;
      cyc_cnt_q  <= '0;
      acq_cnt_q  <= '0;
      rise_cnt_q <= '0;
      conv_q     <= 1'b0;
      sck_q      <= 1'b0;
      sleep_q    <= 1'b0;
      valid_q    <= 1'b0;
      stale_q    <= 1'b0;
      result_q   <= '0;
      tag_q      <= '0;
    end else begin
      valid_q <= 1'b0;
      if (cyc_cnt_q != '0) cyc_cnt_q <= cyc_cnt_q - 1'b1;
      if (acq_cnt_q != '0) acq_cnt_q <= acq_cnt_q - 1'b1;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q   <= ST_CONV;
          conv_q    <= 1'b1;
          sleep_q   <= sleep_i;
          cnv_cnt_q <= CNV_W'(CONV_CYC - 1);
          cyc_cnt_q <= CYC_W'(CYCLE_CYC - 1);
        end
        ST_CONV: begin
          if (cnv_cnt_q == '0) begin
            conv_q  <= 1'b0;
            state_q <= ST_LEAD;
          end else begin
            cnv_cnt_q <= cnv_cnt_q - 1'b1;
            if (!sleep_q && cnv_cnt_q == CNV_W'(CONV_CYC - CONV_HI_CYC)) conv_q <= 1'b0;
          end
        end
        ST_LEAD: if (tick) begin
          sck_q      <= 1'b1;
          rise_cnt_q <= RC_W'(1);
          state_q    <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (sck_q) begin
            sck_q <= 1'b0;
            if (rise_cnt_q == RC_W'(DATA_W)) begin
              state_q  <= ST_IDLE;
              valid_q  <= 1'b1;
              result_q <= shift_data;
              tag_q    <= prev_cfg;
              stale_q  <= !prev_vld;
            end
          end else begin
            sck_q      <= 1'b1;
            rise_cnt_q <= rise_cnt_q + 1'b1;
            // last setup bit latched: acquisition window opens
            if (rise_cnt_q == RC_W'(SARH_CFG_W - 1)) acq_cnt_q <= ACQ_W'(ACQ_CYC - 1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_o         = conv_q;
  assign sck_o          = sck_q;
  assign result_o       = result_q;
  assign result_valid_o = valid_q;
  assign result_tag_o   = tag_q;
  assign result_stale_o = stale_q;
endmodule

// File: rtl/sarh_host_chk.sv
module sarh_host_chk #(
  parameter int SCK_HALF  = 2,
  parameter int CONV_CYC  = 10,
  parameter int CYCLE_CYC = 64,
  parameter int CFG_W     = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic conv_o,
  input logic sck_o,
  input logic sdi_o,
  input logic result_valid_o,
  input logic result_stale_o
);
  logic        conv_d, sck_d, seen_conv, seen_valid;
  logic [15:0] since_conv, stable_cnt;
  logic [7:0]  rises;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_d     <= 1'b0;
      sck_d      <= 1'b0;
      seen_conv  <= 1'b0;
      seen_valid <= 1'b0;
      since_conv <= '0;
      stable_cnt <= '0;
      rises      <= '0;
    end else begin
      conv_d <= conv_o;
      sck_d  <= sck_o;
      if (result_valid_o) seen_valid <= 1'b1;
      if (conv_o && !conv_d) begin
        seen_conv  <= 1'b1;
        since_conv <= 16'd1;
        rises      <= '0;
      end else begin
        if (since_conv != 16'hFFFF) since_conv <= since_conv + 1'b1;
        if (sck_o && !sck_d) rises <= rises + 1'b1;
      end
      if (sck_o != sck_d) stable_cnt <= 16'd1;
      else if (stable_cnt != 16'hFFFF) stable_cnt <= stable_cnt + 1'b1;
    end
  end

  p_sck_low_in_conv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> !sck_o);
  p_first_sck_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && !sck_d) |-> (since_conv >= 16'(CONV_CYC)));
  p_half_period_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o != sck_d) |-> (stable_cnt >= 16'(SCK_HALF)));
  p_sdi_tail_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rises >= 8'(CFG_W) && !sck_o && !conv_o) |-> !sdi_o);
  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);
  p_valid_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> (!sck_o && !conv_o));
  p_stale_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && !seen_valid) |-> result_stale_o);
  p_stale_later_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && seen_valid) |-> !result_stale_o);
  p_cycle_space_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_o && !conv_d && seen_conv) |-> (since_conv >= 16'(CYCLE_CYC)));
endmodule

bind sarh_host_ctrl sarh_host_chk #(
  .SCK_HALF  (SCK_HALF),
  .CONV_CYC  (CONV_CYC),
  .CYCLE_CYC (CYCLE_CYC),
  .CFG_W     (sarh_pkg::SARH_CFG_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .conv_o         (conv_o),
  .sck_o          (sck_o),
  .sdi_o          (sdi_o),
  .result_valid_o (result_valid_o),
  .result_stale_o (result_stale_o)
);

// File: tb/tb_sarh_host_ctrl.sv
`timescale 1ns/1ps
module tb_sarh_host_ctrl;
  localparam int CLK_P       = 10;
  localparam int DATA_W      = 12;
  localparam int SCK_HALF    = 2;
  localparam int CONV_HI_CYC = 2;
  localparam int CONV_CYC    = 10;
  localparam int ACQ_CYC     = 12;
  localparam int CYCLE_CYC   = 64;
  localparam int NFR         = 17;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, single_i = 1'b0, odd_i = 1'b0, unipolar_i = 1'b0, sleep_i = 1'b0;
  logic sdo_m = 1'b0;
  logic conv_o, sck_o, sdi_o, result_valid_o, result_stale_o;
  logic [DATA_W-1:0] result_o;
  logic [2:0] result_tag_o;

  always #(CLK_P/2) clk = ~clk;

  sarh_host_ctrl #(
    .DATA_W(DATA_W), .SCK_HALF(SCK_HALF), .CONV_HI_CYC(CONV_HI_CYC),
    .CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC), .CYCLE_CYC(CYCLE_CYC)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .single_i(single_i),
    .odd_i(odd_i), .unipolar_i(unipolar_i), .sleep_i(sleep_i), .sdo_i(sdo_m),
    .conv_o(conv_o), .sck_o(sck_o), .sdi_o(sdi_o), .result_o(result_o),
    .result_valid_o(result_valid_o), .result_tag_o(result_tag_o),
    .result_stale_o(result_stale_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model: sample code built from the setup word it received
  function automatic logic [11:0] code_of(logic [5:0] w, int idx);
    return {w[5], w[4], w[1], 9'(idx * 37 + 5)};
  endfunction

  logic [11:0] m_word;
  logic [5:0]  m_rx, m_act = '0;
  int  m_idx = 0, m_nr = 0, n_conv = 0;
  bit  tail_bad;
  time t_conv_r, t_conv_prev, t_conv_f, t_sck_first, t_last_sck, t_rise6;
  int  min_half, max_half;

  always @(posedge conv_o) begin
    t_conv_prev = t_conv_r;
    t_conv_r = $time;
    n_conv++;
    m_word = code_of(m_act, m_idx);
    m_idx++;
    sdo_m = m_word[11];
    m_nr = 0; m_rx = '0; tail_bad = 0;
    min_half = 1000000; max_half = 0; t_last_sck = 0;
  end
  always @(negedge conv_o) t_conv_f = $time;

  always @(posedge sck_o) begin
    m_nr++;
    if (m_nr == 1) t_sck_first = $time;
    else begin
      min_half = (int'(($time - t_last_sck) / CLK_P) < min_half) ? int'(($time - t_last_sck) / CLK_P) : min_half;
      max_half = (int'(($time - t_last_sck) / CLK_P) > max_half) ? int'(($time - t_last_sck) / CLK_P) : max_half;
    end
    t_last_sck = $time;
    if (m_nr <= 6) m_rx = {m_rx[4:0], sdi_o};
    else if (sdi_o) tail_bad = 1;
    if (m_nr == 6) begin m_act = m_rx; t_rise6 = $time; end
  end
  always @(negedge sck_o) begin
    min_half = (int'(($time - t_last_sck) / CLK_P) < min_half) ? int'(($time - t_last_sck) / CLK_P) : min_half;
    max_half = (int'(($time - t_last_sck) / CLK_P) > max_half) ? int'(($time - t_last_sck) / CLK_P) : max_half;
    t_last_sck = $time;
    m_word = {m_word[10:0], 1'b0};
    sdo_m = m_word[11];
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R6: actual hang expected result strobe (watchdog)");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [5:0] req_w [NFR];
    logic [2:0] req_t [NFR];
    time prev_r6;
    repeat (3) @(negedge clk);
    check(!conv_o && !sck_o && !sdi_o && !result_valid_o, "R1 in reset", {conv_o, sck_o, sdi_o, result_valid_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check(!conv_o && !sck_o && !sdi_o && !result_valid_o, "R1 after reset", {conv_o, sck_o, sdi_o, result_valid_o}, 0);

    for (int k = 0; k < NFR; k++) begin
      logic [3:0] c;
      c = 4'(k % 16);
      req_w[k] = {c[0], c[1], 2'b00, c[2], 1'b0};
      req_t[k] = {c[0], c[1], c[2]};
      prev_r6 = t_rise6;
      @(negedge clk);
      single_i = c[0]; odd_i = c[1]; unipolar_i = c[2]; sleep_i = c[3];
      start_i = 1'b1;
      @(posedge conv_o);
      @(negedge clk);
      start_i = 1'b0;
      // later input changes must not reach this frame (R7)
      single_i = ~c[0]; odd_i = ~c[1]; unipolar_i = ~c[2]; sleep_i = ~c[3];
      if (k > 0) begin
        check((t_conv_r - t_conv_prev) / CLK_P == CYCLE_CYC, "R9 cycle spacing",
              (t_conv_r - t_conv_prev) / CLK_P, CYCLE_CYC);
        check((t_conv_r - prev_r6) / CLK_P >= ACQ_CYC, "R9 acquisition gap",
              (t_conv_r - prev_r6) / CLK_P, ACQ_CYC);
      end
      repeat (20) @(negedge clk);
      start_i = 1'b1;  // mid-frame request: ignored (R2)
      @(negedge clk);
      start_i = 1'b0;
      do @(negedge clk); while (!result_valid_o);

      check((t_conv_f - t_conv_r) / CLK_P == (c[3] ? CONV_CYC : CONV_HI_CYC),
            c[3] ? "R3 sleep pulse width" : "R2 convert pulse width",
            (t_conv_f - t_conv_r) / CLK_P, c[3] ? CONV_CYC : CONV_HI_CYC);
      check((t_sck_first - t_conv_r) / CLK_P == CONV_CYC + SCK_HALF, "R4 first sck delay",
            (t_sck_first - t_conv_r) / CLK_P, CONV_CYC + SCK_HALF);
      check(m_nr == DATA_W, "R4 pulse count", m_nr, DATA_W);
      check(min_half == SCK_HALF && max_half == SCK_HALF, "R4 half period",
            (min_half == SCK_HALF) ? max_half : min_half, SCK_HALF);
      check(!sck_o, "R4 sck rests low", sck_o, 0);
      check(m_rx == req_w[k], "R5 setup word", m_rx, req_w[k]);
      check(!tail_bad, "R5 sdi low after setup", tail_bad, 0);
      check(result_o == code_of(k == 0 ? 6'd0 : req_w[k-1], k), "R6 R10 result",
            result_o, code_of(k == 0 ? 6'd0 : req_w[k-1], k));
      check(result_stale_o == (k == 0), "R8 stale flag", result_stale_o, k == 0);
      if (k > 0) check(result_tag_o == req_t[k-1], "R7 tag", result_tag_o, req_t[k-1]);
      check(n_conv == k + 1, "R2 ignored start", n_conv, k + 1);
      if (k == NFR - 1) begin
        @(negedge clk);
        check(!result_valid_o, "R6 one-cycle strobe", result_valid_o, 0);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule